// File: doc/BRIEF.md
# I2C Pin-Control Register Target

This block is an I2C target that lets a bus host program a bank of 8-bit registers controlling a set of open-drain pins, and read back the live pin levels. The block oversamples SCL and SDA with the system clock, recognises START, repeated START and STOP, and answers a 7-bit address. After the address, the first written byte is a command byte: it loads a 4-bit register pointer and an auto-increment flag. Further written bytes land in the register the pointer selects. A read sends the selected register. The read may follow a command write and a repeated START, or start directly from the current pointer.

Each pin owns a 2-bit selector field. The field pulls the pin low, releases it, or lets one of two externally generated blink waveforms drive it. The pins are open-drain, so the blink waveform pulls the pin low while the waveform is low. The input registers hold pin levels. These levels are sampled at the falling SCL edge that closes each acknowledge clock, just before the byte goes out. With the default of 16 pins there are two input registers and four selector registers.

Top module: `i2c_pin_ctrl`

## Requirements
- R1: The target address is binary 1100 in bits 6..3, followed by `addr_sel_i[2:0]` in bits 2..0. The eighth bit is R/W: 0 means write and 1 means read. On a match the target acknowledges by pulling SDA low during the ninth clock.
- R2: On an address mismatch the target does not acknowledge. It then ignores every following clock, and changes no register, until the next START or STOP.
- R3: The first byte after a write address is the command byte. Bits 3..0 load the pointer and bit 4 loads the auto-increment flag. Bits 7..5 are ignored.
- R4: Each further written byte is stored in the register at the pointer, and every written byte is acknowledged. With the flag at 1 the pointer then steps by one. With the flag at 0 the pointer stays put, so repeated bytes overwrite the same register.
- R5: When the flag is 1 and the pointer is at or above the last implemented index (5 by default), the next step sets it to 0. Otherwise the step adds one.
- R6: A read is a write of address and command byte, then a repeated START, then the address with R/W=1. The target sends the pointed register MSB first. With the flag set, each byte the host acknowledges is followed by the next register. A host NACK ends the byte stream.
- R7: Index 0 reads pins 7..0 and index 1 reads pins 15..8, with the pin number equal to the bit number. Pin levels are captured at the falling SCL edge that ends the acknowledge clock before each byte. Writes to indices 0 and 1 are acknowledged and discarded.
- R8: Indices 6 to 15 are unimplemented. They read as 0x00, and writes to them are acknowledged and discarded.
- R9: Selector register 2+k holds pins 4k..4k+3, with pin 4k+j in bits 2j+1..2j. Code 00 pulls the pin low. Code 01 releases it. Code 10 pulls it low while `blink0_i` is low. Code 11 pulls it low while `blink1_i` is low.
- R10: A STOP at any point ends the transfer and releases SDA. Clock pulses after a STOP, without a new START, are ignored. The target changes its SDA drive only while SCL is low.
- R11: After reset every selector register holds 0x55, so all pins are released. SDA is released, and the pointer and flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_pull_low_o | output | 1 | 1 pulls SDA low (open-drain) |
| addr_sel_i | input | 3 | Low three bits of the target address |
| pin_i | input | N_PINS | Pin levels read back through the input registers |
| blink0_i | input | 1 | First blink waveform |
| blink1_i | input | 1 | Second blink waveform |
| pin_pull_low_o | output | N_PINS | 1 pulls the pin low (open-drain) |

## Verification
The assertions assume a well-behaved host. SCL high and low phases each last several system clocks, so every edge survives the synchroniser. START and STOP are only issued while the target has released SDA. The bench host holds each quarter bit for eight clocks. It changes SDA only a quarter period after SCL falls, and it asserts START and STOP only outside acknowledge and data-out slots. Pin levels are changed only between bytes, well away from the capture edge.

// File: rtl/i2cpc_pkg.sv
package i2cpc_pkg;

  localparam int PTR_W = 4;
  localparam logic [3:0] ADDR_FIXED = 4'b1100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_IGNORE
  } bus_st_e;

  typedef enum logic [1:0] {
    RK_ADDR,
    RK_CMD,
    RK_DATA
  } rx_kind_e;

  typedef enum logic [1:0] {
    SEL_LOW    = 2'b00,
    SEL_HIZ    = 2'b01,
    SEL_BLINK0 = 2'b10,
    SEL_BLINK1 = 2'b11
  } pin_sel_e;

endpackage

// File: rtl/i2cpc_sync.sv
module i2cpc_sync #(
  parameter int   WIDTH   = 1,
  parameter logic RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= {WIDTH{RST_VAL}};
      stab_q <= {WIDTH{RST_VAL}};
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;

endmodule

// File: rtl/i2cpc_bus_fsm.sv
module i2cpc_bus_fsm
  import i2cpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic [2:0] addr_sel_i,
  input  logic [7:0] rd_data_i,
  output logic       sda_pull_low_o,
  output logic       cmd_we_o,
  output logic       data_we_o,
  output logic       rd_load_o,
  output logic [7:0] rx_byte_o,
  output logic       stop_o
);

  logic     scl_q, sda_q;
  bus_st_e  st_q, st_d;
  rx_kind_e kind_q, kind_d;
  logic [2:0] cnt_q, cnt_d;
  logic       full_q, full_d;
  logic [7:0] shift_q, shift_d;
  logic       rdm_q, rdm_d;
  logic       mack_q, mack_d;
  logic       drive_q, drive_d;

  logic scl_rise, scl_fall, start_det, stop_det, addr_hit;

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  assign addr_hit  = (shift_q[7:1] == {ADDR_FIXED, addr_sel_i});

  always_comb begin
    st_d      = st_q;
    kind_d    = kind_q;
    cnt_d     = cnt_q;
    full_d    = full_q;
    shift_d   = shift_q;
    rdm_d     = rdm_q;
    mack_d    = mack_q;
    cmd_we_o  = 1'b0;
    data_we_o = 1'b0;
    rd_load_o = 1'b0;
    if (stop_det) begin
      st_d = ST_IDLE;
    end else if (start_det) begin
      st_d   = ST_RX;
      kind_d = RK_ADDR;
      cnt_d  = 3'd0;
      full_d = 1'b0;
      rdm_d  = 1'b0;
    end else begin
      case (st_q)
        ST_RX: begin
          if (scl_rise && !full_q) begin
            shift_d = {shift_q[6:0], sda_s};
            cnt_d   = cnt_q + 3'd1;
            full_d  = (cnt_q == 3'd7);
          end else if (scl_fall && full_q) begin
            full_d = 1'b0;
            cnt_d  = 3'd0;
            case (kind_q)
              RK_ADDR: begin
                if (addr_hit) begin
                  st_d   = ST_RX_ACK;
                  rdm_d  = shift_q[0];
                  kind_d = RK_CMD;
                end else begin
                  st_d = ST_IGNORE;
                end
              end
              RK_CMD: begin
                st_d     = ST_RX_ACK;
                cmd_we_o = 1'b1;
                kind_d   = RK_DATA;
              end
              default: begin
                st_d      = ST_RX_ACK;
                data_we_o = 1'b1;
              end
            endcase
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            if (rdm_q) begin
              st_d      = ST_TX;
              rd_load_o = 1'b1;
              shift_d   = rd_data_i;
              cnt_d     = 3'd0;
            end else begin
              st_d = ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == 3'd7) begin
              st_d = ST_TX_ACK;
            end else begin
              shift_d = {shift_q[6:0], 1'b0};
              cnt_d   = cnt_q + 3'd1;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            mack_d = ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              st_d      = ST_TX;
              rd_load_o = 1'b1;
              shift_d   = rd_data_i;
              cnt_d     = 3'd0;
            end else begin
              st_d = ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
    drive_d = (st_d == ST_RX_ACK) || ((st_d == ST_TX) && !shift_d[7]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      st_q    <= ST_IDLE;
      kind_q  <= RK_ADDR;
      cnt_q   <= 3'd0;
      full_q  <= 1'b0;
      shift_q <= 8'h00;
      rdm_q   <= 1'b0;
      mack_q  <= 1'b0;
      drive_q <= 1'b0;
    end else begin
      scl_q   <= scl_s;
      sda_q   <= sda_s;
      st_q    <= st_d;
      kind_q  <= kind_d;
      cnt_q   <= cnt_d;
      full_q  <= full_d;
      shift_q <= shift_d;
      rdm_q   <= rdm_d;
      mack_q  <= mack_d;
      drive_q <= drive_d;
    end
  end

  assign sda_pull_low_o = drive_q;
  assign rx_byte_o      = shift_q;
  assign stop_o         = stop_det;

endmodule

// File: rtl/i2cpc_regbank.sv
module i2cpc_regbank
  import i2cpc_pkg::*;
#(
  parameter int N_PINS = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_we_i,
  input  logic                  data_we_i,
  input  logic                  rd_load_i,
  input  logic [7:0]            wr_byte_i,
  input  logic [N_PINS-1:0]     pins_i,
  output logic [7:0]            rd_data_o,
  output logic [2*N_PINS-1:0]   sel_flat_o,
  output logic [PTR_W-1:0]      ptr_o,
  output logic                  adv_o
);

  localparam int IN_REGS  = N_PINS / 8;
  localparam int SEL_REGS = N_PINS / 4;
  localparam int NREG     = IN_REGS + SEL_REGS;
  localparam int NUM_IDX  = 2 ** PTR_W;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NREG - 1);

  logic [PTR_W-1:0]      ptr_q, ptr_d, ptr_inc;
  logic                  ai_q, ai_d;
  logic [8*SEL_REGS-1:0] sel_q;
  logic [SEL_REGS-1:0]   sel_we;
  logic [7:0]            rd_word [NUM_IDX];

  assign adv_o   = ai_q & (data_we_i | rd_load_i);
  assign ptr_inc = (ptr_q >= LAST) ? '0 : ptr_q + 1'b1;

  always_comb begin
    ptr_d = ptr_q;
    ai_d  = ai_q;
    if (cmd_we_i) begin
      ptr_d = wr_byte_i[PTR_W-1:0];
      ai_d  = wr_byte_i[4];
    end else if (adv_o) begin
      ptr_d = ptr_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      ai_q  <= 1'b0;
    end else begin
      ptr_q <= ptr_d;
      ai_q  <= ai_d;
    end
  end

  genvar gk;
  generate
    for (gk = 0; gk < SEL_REGS; gk++) begin : g_we
      assign sel_we[gk] = data_we_i && (ptr_q == PTR_W'(IN_REGS + gk));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= {SEL_REGS{8'h55}};
    end else begin
      for (int k = 0; k < SEL_REGS; k++) begin
        if (sel_we[k]) begin
          sel_q[8*k +: 8] <= wr_byte_i;
        end
      end
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_IDX; gi++) begin : g_word
      if (gi < IN_REGS) begin : g_in
        assign rd_word[gi] = pins_i[8*gi +: 8];
      end else if (gi < NREG) begin : g_sel
        assign rd_word[gi] = sel_q[8*(gi-IN_REGS) +: 8];
      end else begin : g_none
        assign rd_word[gi] = 8'h00;
      end
    end
  endgenerate

  assign rd_data_o  = rd_word[ptr_q];
  assign sel_flat_o = sel_q;
  assign ptr_o      = ptr_q;

endmodule

// File: rtl/i2cpc_pin_out.sv
module i2cpc_pin_out
  import i2cpc_pkg::*;
#(
  parameter int N_PINS = 16
) (
  input  logic [2*N_PINS-1:0] sel_flat_i,
  input  logic                blink0_i,
  input  logic                blink1_i,
  output logic [N_PINS-1:0]   pull_low_o
);

  genvar gp;
  generate
    for (gp = 0; gp < N_PINS; gp++) begin : g_pin
      pin_sel_e code;
      assign code = pin_sel_e'(sel_flat_i[2*gp +: 2]);
      always_comb begin
        case (code)
          SEL_LOW:    pull_low_o[gp] = 1'b1;
          SEL_HIZ:    pull_low_o[gp] = 1'b0;
          SEL_BLINK0: pull_low_o[gp] = ~blink0_i;
          default:    pull_low_o[gp] = ~blink1_i;
        endcase
      end
    end
  endgenerate

endmodule

// File: rtl/i2c_pin_ctrl.sv
module i2c_pin_ctrl
  import i2cpc_pkg::*;
#(
  parameter int N_PINS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_low_o,
  input  logic [2:0]        addr_sel_i,
  input  logic [N_PINS-1:0] pin_i,
  input  logic              blink0_i,
  input  logic              blink1_i,
  output logic [N_PINS-1:0] pin_pull_low_o
);

  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [1:0]          bus_s;
  logic                scl_s, sda_s;
  logic [N_PINS-1:0]   pins_s;
  logic [7:0]          rd_data, rx_byte;
  logic                cmd_we, data_we, rd_load, stop_det, adv;
  logic [2*N_PINS-1:0] sel_flat;
  logic [PTR_W-1:0]    ptr;

  i2cpc_sync #(.WIDTH(2), .RST_VAL(1'b1)) u_bus_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   ({scl_i, sda_i}),
    .q_o   (bus_s)
  );

  assign scl_s = bus_s[1];
  assign sda_s = bus_s[0];

  i2cpc_sync #(.WIDTH(N_PINS), .RST_VAL(1'b0)) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   (pin_i),
    .q_o   (pins_s)
  );

  i2cpc_bus_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .scl_s          (scl_s),
    .sda_s          (sda_s),
    .addr_sel_i     (addr_sel_i),
    .rd_data_i      (rd_data),
    .sda_pull_low_o (sda_pull_low_o),
    .cmd_we_o       (cmd_we),
    .data_we_o      (data_we),
    .rd_load_o      (rd_load),
    .rx_byte_o      (rx_byte),
    .stop_o         (stop_det)
  );

  i2cpc_regbank #(.N_PINS(N_PINS)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cmd_we_i   (cmd_we),
    .data_we_i  (data_we),
    .rd_load_i  (rd_load),
    .wr_byte_i  (rx_byte),
    .pins_i     (pins_s),
    .rd_data_o  (rd_data),
    .sel_flat_o (sel_flat),
    .ptr_o      (ptr),
    .adv_o      (adv)
  );

  i2cpc_pin_out #(.N_PINS(N_PINS)) u_pins (
    .sel_flat_i (sel_flat),
    .blink0_i   (blink0_i),
    .blink1_i   (blink1_i),
    .pull_low_o (pin_pull_low_o)
  );

endmodule

// File: rtl/i2cpc_checker.sv
module i2cpc_checker
  import i2cpc_pkg::*;
#(
  parameter int N_PINS = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                scl_s,
  input logic                stop_det,
  input logic                sda_pull_low,
  input logic                data_we,
  input logic [2*N_PINS-1:0] sel_flat,
  input logic                adv,
  input logic [PTR_W-1:0]    ptr
);

  localparam int NREG = N_PINS / 8 + N_PINS / 4;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NREG - 1);

  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  // R10: SDA drive only moves while SCL is low
  p_sda_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
    (scl_s && $past(scl_s)) |-> $stable(sda_pull_low));

  // R10: a STOP leaves SDA released
  p_release_stop_r10: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
    stop_det |=> !sda_pull_low);

  // R4: selector contents change only on a data-byte strobe
  p_sel_hold_r4: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
    !data_we |=> $stable(sel_flat));

  // R5: an auto-increment step never leaves the implemented range
  p_ptr_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
    adv |=> (ptr <= LAST));

endmodule

bind i2c_pin_ctrl i2cpc_checker #(.N_PINS(N_PINS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .scl_s        (scl_s),
  .stop_det     (stop_det),
  .sda_pull_low (sda_pull_low_o),
  .data_we      (data_we),
  .sel_flat     (sel_flat),
  .adv          (adv),
  .ptr          (ptr)
);

// File: tb/tb_i2c_pin_ctrl.sv
`timescale 1ns/1ps
module tb_i2c_pin_ctrl;

  localparam int NP = 16;
  localparam int Q  = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          scl_m, sda_m;
  logic [2:0]    asel;
  logic [NP-1:0] pins;
  logic          b0, b1;
  wire           sda_pull;
  wire [NP-1:0]  pl;
  wire           sda_bus = sda_m & ~sda_pull;

  always #2.5 clk = ~clk;

  i2c_pin_ctrl #(.N_PINS(NP)) dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .scl_i          (scl_m),
    .sda_i          (sda_bus),
    .sda_pull_low_o (sda_pull),
    .addr_sel_i     (asel),
    .pin_i          (pins),
    .blink0_i       (b0),
    .blink1_i       (b1),
    .pin_pull_low_o (pl)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [7:0] sel_m [4];
  logic [3:0] m_ptr;
  logic       m_ai;
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  task automatic wbit(input logic b);
    sda_m = b; wq(Q);
    scl_m = 1'b1; wq(2*Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic rbit(output logic b);
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    b = sda_bus; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    ack = ~sda_bus; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic rbyte(input logic mack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) rbit(d[i]);
    wbit(~mack);
  endtask

  function automatic logic [7:0] exp_reg(input logic [3:0] idx);
    case (idx)
      4'd0: exp_reg = pins[7:0];
      4'd1: exp_reg = pins[15:8];
      4'd2, 4'd3, 4'd4, 4'd5: exp_reg = sel_m[idx-2];
      default: exp_reg = 8'h00;
    endcase
  endfunction

  function automatic logic [3:0] step(input logic [3:0] p);
    step = (p >= 4'd5) ? 4'd0 : p + 4'd1;
  endfunction

  function automatic logic [NP-1:0] exp_pins(input logic bl0, input logic bl1);
    logic [NP-1:0] r;
    for (int p = 0; p < NP; p++) begin
      case (sel_m[p/4][2*(p%4) +: 2])
        2'b00: r[p] = 1'b1;
        2'b01: r[p] = 1'b0;
        2'b10: r[p] = ~bl0;
        default: r[p] = ~bl1;
      endcase
    end
    return r;
  endfunction

  // full write transfer; returns number of acknowledged bytes
  task automatic xfer_write(input logic [2:0] a, input logic [7:0] cmd, input int n, output int acks);
    logic ak;
    acks = 0;
    bus_start();
    wbyte({4'hC, a, 1'b0}, ak); acks += int'(ak);
    wbyte(cmd, ak); acks += int'(ak);
    for (int i = 0; i < n; i++) begin
      wbyte(wbuf[i], ak); acks += int'(ak);
    end
    bus_stop();
    if (a == asel) begin
      m_ptr = cmd[3:0];
      m_ai  = cmd[4];
      for (int i = 0; i < n; i++) begin
        if (m_ptr >= 4'd2 && m_ptr <= 4'd5) sel_m[m_ptr-2] = wbuf[i];
        if (m_ai) m_ptr = step(m_ptr);
      end
    end
  endtask

  task automatic read_check(input string req, input logic [7:0] cmd, input int n);
    logic ak;
    logic [3:0] p;
    bus_start();
    wbyte({4'hC, asel, 1'b0}, ak);
    wbyte(cmd, ak);
    bus_rstart();
    wbyte({4'hC, asel, 1'b1}, ak);
    for (int i = 0; i < n; i++) rbyte(i != n-1, rbuf[i]);
    bus_stop();
    p = cmd[3:0];
    for (int i = 0; i < n; i++) begin
      chk(req, $sformatf("read byte %0d idx %0d", i, p), {8'h00, rbuf[i]}, {8'h00, exp_reg(p)});
      if (cmd[4]) p = step(p);
    end
  endtask

  task automatic check_pins(input string req);
    for (int c = 0; c < 4; c++) begin
      b0 = c[0]; b1 = c[1];
      wq(1);
      chk(req, $sformatf("pin drive blink=%0d", c), pl, exp_pins(c[0], c[1]));
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int acks;
    logic ak;
    logic [15:0] pa, pb;
    void'($urandom(32'd4711));
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; asel = 3'b010;
    pins = 16'h3C5A; b0 = 1'b0; b1 = 1'b1;
    for (int k = 0; k < 4; k++) sel_m[k] = 8'h55;
    m_ptr = 4'd0; m_ai = 1'b0;
    wq(10);
    rst_n = 1'b1;
    wq(10);

    // R11 reset state
    chk("R11", "sda after reset", {15'd0, sda_pull}, 16'd0);
    chk("R11", "pins after reset", pl, 16'd0);
    read_check("R11", 8'h12, 4);

    // R1 address match and mismatch on the hardware bits
    asel = 3'b101;
    wbuf[0] = 8'h00;
    xfer_write(3'b101, 8'h02, 1, acks);
    chk("R1", "acks matching address", 16'(acks), 16'd3);
    check_pins("R9");

    // R2 mismatch: no ack, nothing written
    wbuf[0] = 8'hFF; wbuf[1] = 8'hAA;
    xfer_write(3'b100, 8'h12, 2, acks);
    chk("R2", "acks wrong address", 16'(acks), 16'd0);
    read_check("R2", 8'h12, 4);

    // R4 AI=0: pointer fixed, last byte wins
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'hE4;
    xfer_write(asel, 8'h03, 3, acks);
    chk("R4", "acks fixed pointer", 16'(acks), 16'd5);
    read_check("R4", 8'h12, 4);

    // R5 and R7: wrap through read-only inputs back to selectors
    wbuf[0] = 8'h9C; wbuf[1] = 8'h36; wbuf[2] = 8'h00; wbuf[3] = 8'h00; wbuf[4] = 8'hB1;
    xfer_write(asel, 8'h14, 5, acks);
    chk("R7", "acks incl read-only", 16'(acks), 16'd7);
    read_check("R5", 8'h12, 4);
    check_pins("R9");

    // R3 upper command bits ignored
    wbuf[0] = 8'h6D;
    xfer_write(asel, 8'hE3, 1, acks);
    read_check("R3", 8'h03, 1);

    // R8 unimplemented indices
    wbuf[0] = 8'h77;
    xfer_write(asel, 8'h09, 1, acks);
    chk("R8", "acks unimplemented", 16'(acks), 16'd3);
    read_check("R8", 8'h09, 1);
    read_check("R5", 8'h1F, 3);

    // R7 capture at acknowledge falling edge
    pa = 16'hA5C3; pb = 16'h5A3C;
    pins = pa; wq(4);
    bus_start();
    wbyte({4'hC, asel, 1'b0}, ak);
    wbyte(8'h10, ak);
    bus_rstart();
    wbyte({4'hC, asel, 1'b1}, ak);
    pins = pb;
    rbyte(1'b1, rbuf[0]);
    rbyte(1'b0, rbuf[1]);
    bus_stop();
    chk("R7", "input low byte at first capture", {8'h00, rbuf[0]}, {8'h00, pa[7:0]});
    chk("R7", "input high byte at second capture", {8'h00, rbuf[1]}, {8'h00, pb[15:8]});
    pins = pa; wq(4);
    bus_start();
    wbyte({4'hC, asel, 1'b0}, ak);
    wbyte(8'h00, ak);
    bus_rstart();
    wbyte({4'hC, asel, 1'b1}, ak);
    pins = pb;
    rbyte(1'b1, rbuf[0]);
    rbyte(1'b0, rbuf[1]);
    bus_stop();
    chk("R7", "fixed pointer first capture", {8'h00, rbuf[0]}, {8'h00, pa[7:0]});
    chk("R7", "fixed pointer second capture", {8'h00, rbuf[1]}, {8'h00, pb[7:0]});

    // R10 STOP in mid byte, then clocks without START
    bus_start();
    wbyte({4'hC, asel, 1'b0}, ak);
    wbyte(8'h02, ak);
    for (int i = 0; i < 4; i++) wbit(1'b0);
    bus_stop();
    chk("R10", "sda released after stop", {15'd0, sda_pull}, 16'd0);
    wbyte({4'hC, asel, 1'b0}, ak);
    chk("R10", "no ack without start", {15'd0, ak}, 16'd0);
    wbyte(8'h02, ak);
    wbyte(8'h00, ak);
    bus_stop();
    read_check("R10", 8'h12, 4);

    // random mix
    for (int it = 0; it < 20; it++) begin
      int n;
      logic [2:0] a;
      logic [7:0] cmd;
      asel = 3'($urandom_range(0, 7));
      a = ($urandom_range(0, 7) == 0) ? (asel ^ 3'b001) : asel;
      n = $urandom_range(1, 5);
      cmd = {3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), 4'($urandom_range(0, 7))};
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      xfer_write(a, cmd, n, acks);
      chk((a == asel) ? "R4" : "R2", "random acks", 16'(acks), (a == asel) ? 16'(n + 2) : 16'd0);
      check_pins("R9");
      pins = 16'($urandom); wq(4);
      read_check("R6", {3'b000, 1'b1, 4'($urandom_range(0, 7))}, 3);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule